// File: doc/BRIEF.md
# Instruction-Boundary Event Arbiter

This block sits beside a processor core's sequencer. It picks the single event the core services next, and that choice happens only when the core signals that one instruction has ended and the next has not begun. A repeated string instruction raises that signal between its iterations. The candidates come from several sources:

- instruction faults;
- trap instructions;
- debug traps and debug faults;
- a non-maskable interrupt pin;
- a maskable interrupt pin, whose vector is supplied from outside.

The block applies the interrupt-enable and resume flags and a one-boundary shadow after a stack-segment load. One cycle after the boundary it returns the winner's 8-bit vector together with a request to clear the interrupt-enable flag.

Only one event wins per boundary. Exceptions that lose are simply forgotten, because the core rediscovers them when the handler returns. A non-maskable request is edge-captured and waits in a latch until it can be serviced. Once such an event has been serviced, new non-maskable events are held back until the core reports a return-from-interrupt. The maskable pin is sampled as a level and is never remembered.

Top module: `evt_boundary_arbiter`

## Requirements
- R1: An event is dispatched only for a cycle with `bnd_i`=1. `take_o` is high for exactly the one cycle after that boundary cycle. `vec_o` is updated in that same cycle and holds its value otherwise. A cycle without `bnd_i` never produces `take_o`.
- R2: Class priority, highest first:
  1. instruction fault;
  2. trap instruction;
  3. debug trap;
  4. debug fault;
  5. non-maskable interrupt;
  6. maskable interrupt.
- R3: The fault and trap-instruction vectors are passed through from `flt_vec_i` and `trp_vec_i`. Both debug classes give vector 1. The non-maskable class gives vector 2. The maskable class gives `intr_vec_i`.
- R4: A losing exception is discarded, so it is not dispatched at a later boundary unless it is requested again. A losing non-maskable request stays pending and wins a later boundary.
- R5: A rising edge on `nmi_i` is latched in the cycle it is seen. It can win from the next cycle on. Once a non-maskable event is taken, no further non-maskable event is dispatched until an `iret_i` pulse. An edge that arrives while blocked is kept and served after that pulse.
- R6: The maskable interrupt is taken only while `intr_i`=1 and `if_i`=1 at the boundary. It is level-sensitive and is not latched.
- R7: After an `ss_ld_i` pulse, the next boundary suppresses debug traps, debug faults, non-maskable and maskable interrupts. Instruction faults are still taken there, and the boundary after that is unaffected.
- R8: With `rf_i`=1 debug faults are not recognised; debug traps still are.
- R9: `clr_if_o` pulses with `take_o` when the winning class has its bit set in `CLR_IF_MASK`. The bits are indexed by class rank 0..5, fault first. The default is all ones.
- R10: If a maskable interrupt is taken with a vector below 32, the vector is still passed through unchanged and `vec_err_o` pulses with `take_o`.
- R11: Synchronous active-high `rst` clears the outputs, the pending non-maskable latch, the non-maskable block and the shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bnd_i | input | 1 | Instruction-boundary strobe |
| flt_req_i | input | 1 | Instruction fault request |
| flt_vec_i | input | 8 | Fault vector |
| trp_req_i | input | 1 | Trap-instruction request |
| trp_vec_i | input | 8 | Trap-instruction vector |
| dbg_flt_i | input | 1 | Debug fault for the next instruction |
| dbg_trp_i | input | 1 | Debug trap for the current instruction |
| nmi_i | input | 1 | Non-maskable interrupt pin |
| intr_i | input | 1 | Maskable interrupt pin (level) |
| intr_vec_i | input | 8 | Externally supplied maskable vector |
| if_i | input | 1 | Interrupt-enable flag |
| rf_i | input | 1 | Resume flag |
| ss_ld_i | input | 1 | Current instruction loads the stack segment |
| iret_i | input | 1 | Return-from-interrupt executed |
| take_o | output | 1 | Dispatch strobe |
| vec_o | output | 8 | Dispatched vector |
| clr_if_o | output | 1 | Request to clear the interrupt-enable flag |
| vec_err_o | output | 1 | Maskable vector below 32 |

## Verification
The bench loads a boundary with every class active at once and then removes the winners one by one, which exposes a swapped priority as a wrong vector. It holds a non-maskable edge through boundaries that higher classes win. It also raises a second edge while blocked, so that a design dropping the latch, or ignoring the return pulse, misses the expected vector 2 or takes it too early. The stack-segment shadow is tested with a fault that must still win at that boundary and a maskable request that must win at the following one. Resume-flag masking, a disabled interrupt flag and a low external vector are each checked at the outputs.

// File: rtl/evt_arb_pkg.sv
package evt_arb_pkg;
  localparam int VEC_W   = 8;
  localparam int NCLS    = 6;

  typedef enum logic [2:0] {
    C_FAULT = 3'd0,
    C_TRAPI = 3'd1,
    C_DBGT  = 3'd2,
    C_DBGF  = 3'd3,
    C_NMI   = 3'd4,
    C_INTR  = 3'd5
  } evt_cls_e;

  localparam logic [VEC_W-1:0] VEC_DEBUG   = 8'd1;
  localparam logic [VEC_W-1:0] VEC_NMI     = 8'd2;
  localparam logic [VEC_W-1:0] EXT_VEC_MIN = 8'd32;

  // External vectors must lie in the range above the reserved block.
  function automatic logic ext_vec_low(input logic [VEC_W-1:0] v);
    return v < EXT_VEC_MIN;
  endfunction

  function automatic int cls_idx(input evt_cls_e c);
    return int'(c);
  endfunction
endpackage

// File: rtl/arb_nmi_track.sv
module arb_nmi_track (
  input  logic clk,
  input  logic rst,
  input  logic nmi_i,
  input  logic take_nmi,
  input  logic iret_i,
  output logic nmi_pend,
  output logic nmi_blk
);
  logic nmi_prev;
  logic nmi_edge;

  assign nmi_edge = nmi_i & ~nmi_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_prev <= 1'b0;
      nmi_pend <= 1'b0;
      nmi_blk  <= 1'b0;
    end else begin
      nmi_prev <= nmi_i;
      // a fresh edge outranks the consume of an older request
      if (nmi_edge)      nmi_pend <= 1'b1;
      else if (take_nmi) nmi_pend <= 1'b0;
      if (take_nmi)      nmi_blk  <= 1'b1;
      else if (iret_i)   nmi_blk  <= 1'b0;
    end
  end
endmodule

// File: rtl/arb_shadow.sv
module arb_shadow (
  input  logic clk,
  input  logic rst,
  input  logic ss_ld_i,
  input  logic bnd_i,
  output logic shd_act
);
  always_ff @(posedge clk) begin
    if (rst)        shd_act <= 1'b0;
    else if (bnd_i) shd_act <= ss_ld_i;
    else            shd_act <= shd_act | ss_ld_i;
  end
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [N:0] higher;
  assign higher[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_rank
    assign grant[i]    = req[i] & ~higher[i];
    assign higher[i+1] = higher[i] | req[i];
  end
endmodule

// File: rtl/evt_boundary_arbiter.sv
module evt_boundary_arbiter
  import evt_arb_pkg::*;
#(
  parameter logic [NCLS-1:0] CLR_IF_MASK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bnd_i,
  input  logic             flt_req_i,
  input  logic [VEC_W-1:0] flt_vec_i,
  input  logic             trp_req_i,
  input  logic [VEC_W-1:0] trp_vec_i,
  input  logic             dbg_flt_i,
  input  logic             dbg_trp_i,
  input  logic             nmi_i,
  input  logic             intr_i,
  input  logic [VEC_W-1:0] intr_vec_i,
  input  logic             if_i,
  input  logic             rf_i,
  input  logic             ss_ld_i,
  input  logic             iret_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             clr_if_o,
  output logic             vec_err_o
);
  logic [NCLS-1:0]  cand;
  logic [NCLS-1:0]  grant;
  logic             nmi_pend;
  logic             nmi_blk;
  logic             shd_act;
  logic             take_nmi;
  logic [VEC_W-1:0] vec_tab [NCLS];
  logic [VEC_W-1:0] vec_sel;

  arb_nmi_track u_nmi (
    .clk      (clk),
    .rst      (rst),
    .nmi_i    (nmi_i),
    .take_nmi (take_nmi),
    .iret_i   (iret_i),
    .nmi_pend (nmi_pend),
    .nmi_blk  (nmi_blk)
  );

  arb_shadow u_shd (
    .clk     (clk),
    .rst     (rst),
    .ss_ld_i (ss_ld_i),
    .bnd_i   (bnd_i),
    .shd_act (shd_act)
  );

  // candidate per class, qualified by boundary, flags and shadow
  always_comb begin
    cand = '0;
    cand[cls_idx(C_FAULT)] = bnd_i & flt_req_i;
    cand[cls_idx(C_TRAPI)] = bnd_i & trp_req_i;
    cand[cls_idx(C_DBGT)]  = bnd_i & dbg_trp_i & ~shd_act;
    cand[cls_idx(C_DBGF)]  = bnd_i & dbg_flt_i & ~rf_i & ~shd_act;
    cand[cls_idx(C_NMI)]   = bnd_i & nmi_pend & ~nmi_blk & ~shd_act;
    cand[cls_idx(C_INTR)]  = bnd_i & intr_i & if_i & ~shd_act;
  end

  arb_pick #(.N(NCLS)) u_pick (
    .req   (cand),
    .grant (grant)
  );

  assign take_nmi = grant[cls_idx(C_NMI)];

  always_comb begin
    vec_tab[cls_idx(C_FAULT)] = flt_vec_i;
    vec_tab[cls_idx(C_TRAPI)] = trp_vec_i;
    vec_tab[cls_idx(C_DBGT)]  = VEC_DEBUG;
    vec_tab[cls_idx(C_DBGF)]  = VEC_DEBUG;
    vec_tab[cls_idx(C_NMI)]   = VEC_NMI;
    vec_tab[cls_idx(C_INTR)]  = intr_vec_i;
  end

  // one-hot AND-OR select
  always_comb begin
    vec_sel = '0;
    for (int i = 0; i < NCLS; i++) begin
      vec_sel = vec_sel | (grant[i] ? vec_tab[i] : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o    <= 1'b0;
      vec_o     <= '0;
      clr_if_o  <= 1'b0;
      vec_err_o <= 1'b0;
    end else begin
      take_o    <= |grant;
      clr_if_o  <= |(grant & CLR_IF_MASK);
      vec_err_o <= grant[cls_idx(C_INTR)] & ext_vec_low(intr_vec_i);
      if (|grant) vec_o <= vec_sel;
    end
  end
endmodule

// File: rtl/evt_arb_checker.sv
module evt_arb_checker
  import evt_arb_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            bnd_i,
  input logic            if_i,
  input logic            rf_i,
  input logic            take_o,
  input logic            vec_err_o,
  input logic [NCLS-1:0] grant,
  input logic            nmi_blk,
  input logic            shd_act
);
  assert_take_after_bnd_R1: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(bnd_i));

  assert_no_bnd_no_grant_R1: assert property (@(posedge clk) disable iff (rst)
    !bnd_i |-> grant == '0);

  assert_single_winner_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_nmi_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    grant[cls_idx(C_NMI)] |=> nmi_blk);

  assert_nmi_no_nest_R5: assert property (@(posedge clk) disable iff (rst)
    nmi_blk |-> !grant[cls_idx(C_NMI)]);

  assert_intr_needs_if_R6: assert property (@(posedge clk) disable iff (rst)
    grant[cls_idx(C_INTR)] |-> if_i);

  assert_shadow_masks_R7: assert property (@(posedge clk) disable iff (rst)
    shd_act |-> grant[5:2] == 4'b0000);

  assert_rf_masks_dbgf_R8: assert property (@(posedge clk) disable iff (rst)
    grant[cls_idx(C_DBGF)] |-> !rf_i);

  assert_err_with_take_R10: assert property (@(posedge clk) disable iff (rst)
    vec_err_o |-> take_o);
endmodule

bind evt_boundary_arbiter evt_arb_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .bnd_i     (bnd_i),
  .if_i      (if_i),
  .rf_i      (rf_i),
  .take_o    (take_o),
  .vec_err_o (vec_err_o),
  .grant     (grant),
  .nmi_blk   (nmi_blk),
  .shd_act   (shd_act)
);

// File: tb/evt_boundary_arbiter_test.sv
module evt_boundary_arbiter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bnd_i = 0, flt_req_i = 0, trp_req_i = 0, dbg_flt_i = 0, dbg_trp_i = 0;
  logic       nmi_i = 0, intr_i = 0, if_i = 0, rf_i = 0, ss_ld_i = 0, iret_i = 0;
  logic [7:0] flt_vec_i = 0, trp_vec_i = 0, intr_vec_i = 0;
  logic       take_o, clr_if_o, vec_err_o;
  logic [7:0] vec_o;

  // values the next step applies
  logic       n_bnd = 0, n_flt = 0, n_trp = 0, n_dbgf = 0, n_dbgt = 0;
  logic       n_nmi = 0, n_intr = 0, n_if = 0, n_rf = 0, n_ss = 0, n_iret = 0;
  logic [7:0] n_fv = 0, n_tv = 0, n_iv = 0;

  typedef struct {
    logic       t;
    logic [7:0] v;
    logic       e;
    string      tag;
  } exp_t;
  exp_t q[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  evt_boundary_arbiter uut (
    .clk(clk), .rst(rst), .bnd_i(bnd_i),
    .flt_req_i(flt_req_i), .flt_vec_i(flt_vec_i),
    .trp_req_i(trp_req_i), .trp_vec_i(trp_vec_i),
    .dbg_flt_i(dbg_flt_i), .dbg_trp_i(dbg_trp_i),
    .nmi_i(nmi_i), .intr_i(intr_i), .intr_vec_i(intr_vec_i),
    .if_i(if_i), .rf_i(rf_i), .ss_ld_i(ss_ld_i), .iret_i(iret_i),
    .take_o(take_o), .vec_o(vec_o), .clr_if_o(clr_if_o), .vec_err_o(vec_err_o)
  );

  // driver: apply staged inputs at the falling edge, queue the expectation
  task automatic step(input logic t, input logic [7:0] v, input logic e, input string tag);
    exp_t x;
    @(negedge clk);
    bnd_i = n_bnd; flt_req_i = n_flt; flt_vec_i = n_fv; trp_req_i = n_trp; trp_vec_i = n_tv;
    dbg_flt_i = n_dbgf; dbg_trp_i = n_dbgt; nmi_i = n_nmi; intr_i = n_intr; intr_vec_i = n_iv;
    if_i = n_if; rf_i = n_rf; ss_ld_i = n_ss; iret_i = n_iret;
    x.t = t; x.v = v; x.e = e; x.tag = tag;
    q.push_back(x);
    n_bnd = 0; n_ss = 0; n_iret = 0;
    n_flt = 0; n_trp = 0; n_dbgf = 0; n_dbgt = 0;
  endtask

  // monitor: compare just after the edge that registers the result
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() != 0) begin
        exp_t x;
        bit bad;
        x = q.pop_front();
        checks++;
        bad = (take_o !== x.t);
        if (x.t) bad = bad | (vec_o !== x.v) | (clr_if_o !== 1'b1) | (vec_err_o !== x.e);
        else     bad = bad | (clr_if_o !== 1'b0) | (vec_err_o !== 1'b0);
        if (bad) begin
          fails++;
          $display("FAIL %s: take=%0b vec=%0d clr=%0b err=%0b expected take=%0b vec=%0d clr=%0b err=%0b",
                   x.tag, take_o, vec_o, clr_if_o, vec_err_o, x.t, x.v, x.t, x.e);
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #2;
    checks++;
    if (take_o !== 0 || vec_o !== 0 || clr_if_o !== 0 || vec_err_o !== 0) begin
      fails++;
      $display("FAIL R11 reset: take=%0b vec=%0d expected take=0 vec=0", take_o, vec_o);
    end

    // R1: requests without a boundary dispatch nothing; NMI edge gets latched here
    n_flt = 1; n_fv = 8'd14; n_nmi = 1; n_intr = 1; n_iv = 8'h40; n_if = 1;
    step(0, 0, 0, "R1 no boundary");

    // R2: every class at once, fault wins
    n_bnd = 1; n_flt = 1; n_fv = 8'd14; n_trp = 1; n_tv = 8'd3; n_dbgt = 1; n_dbgf = 1;
    step(1, 8'd14, 0, "R2 fault wins");
    // R1: take is a single pulse
    step(0, 0, 0, "R1 pulse ends");
    n_bnd = 1; n_trp = 1; n_tv = 8'd4; n_dbgt = 1; n_dbgf = 1;
    step(1, 8'd4, 0, "R2 trap instruction wins / R3 pass-through");
    n_bnd = 1; n_dbgt = 1; n_dbgf = 1;
    step(1, 8'd1, 0, "R2 debug trap wins R3");
    n_bnd = 1; n_dbgf = 1;
    step(1, 8'd1, 0, "R2 debug fault over NMI R3");
    // R4: dropped exceptions do not return, NMI still pending beats INTR
    n_bnd = 1;
    step(1, 8'd2, 0, "R4 NMI kept pending R5");
    n_bnd = 1;
    step(1, 8'h40, 0, "R6 INTR after NMI");

    // R5: second edge while blocked is held until return
    n_nmi = 0; n_intr = 0;
    step(0, 0, 0, "R5 idle");
    n_nmi = 1;
    step(0, 0, 0, "R5 edge latched");
    n_bnd = 1;
    step(0, 0, 0, "R5 NMI blocked");
    n_iret = 1;
    step(0, 0, 0, "R5 return");
    n_bnd = 1;
    step(1, 8'd2, 0, "R5 NMI after return");
    n_iret = 1;
    step(0, 0, 0, "R5 return again");

    // R6: IF gates INTR
    n_intr = 1; n_if = 0; n_iv = 8'h41; n_bnd = 1;
    step(0, 0, 0, "R6 IF clear");
    // R10: low external vector passed through with error flag
    n_if = 1; n_iv = 8'h10; n_bnd = 1;
    step(1, 8'h10, 1, "R10 low vector");
    n_intr = 0; n_iv = 8'h41; n_bnd = 1;
    step(0, 0, 0, "R6 INTR not latched");

    // R7: shadow after SS load
    n_ss = 1;
    step(0, 0, 0, "R7 SS load");
    n_bnd = 1; n_dbgt = 1; n_dbgf = 1; n_intr = 1;
    step(0, 0, 0, "R7 shadow suppresses");
    n_ss = 1;
    step(0, 0, 0, "R7 SS load again");
    n_bnd = 1; n_flt = 1; n_fv = 8'd13;
    step(1, 8'd13, 0, "R7 fault in shadow");
    n_bnd = 1;
    step(1, 8'h41, 0, "R7 shadow over");

    // R8: RF masks debug faults only
    n_intr = 0; n_rf = 1; n_bnd = 1; n_dbgf = 1;
    step(0, 0, 0, "R8 debug fault masked");
    n_bnd = 1; n_dbgt = 1;
    step(1, 8'd1, 0, "R8 debug trap kept R9");
    n_rf = 0;

    // R11: reset discards a latched NMI
    n_nmi = 0;
    step(0, 0, 0, "R11 idle");
    n_nmi = 1;
    step(0, 0, 0, "R11 edge");
    n_nmi = 0;
    step(0, 0, 0, "R11 drop");
    do_reset();
    n_bnd = 1;
    step(0, 0, 0, "R11 NMI cleared");
    step(0, 0, 0, "R11 idle after");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule